// File: doc/BRIEF.md
# DMA Completion Interrupt Controller

This block collects completion pulses from twelve DMA channels, split into two banks of six, and turns them into one level interrupt request for input 3 of the system interrupt controller. Each bank has one 32-bit control word that the CPU reaches over a plain synchronous register bus. The word holds a per-channel enable, a per-channel completion flag, a bank master enable and a bank master flag. Flags that are latched while the master enable is set raise the master flag. The master flag then holds the interrupt request high until software clears the pending flags.

The second bank has two channels, 2 and 3, that cannot be masked. Their completions always latch and always raise the request, whatever their enable bits say. Each bank also has a rescan strobe. A rescan looks at the flags already pending, raises the request again if any of them qualifies, and sets the master flag when the master enable is on. It never creates a new flag. The register bus has no back-pressure: every access is accepted in the cycle it is presented. A write takes effect at the next clock edge, and read data is a combinational view of the addressed word.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset both control words read 0 and `irq` is low.
- R2: Word layout: channel n enable at bit 16+n, master enable at bit 23, channel n flag at bit 24+n, master flag at bit 31, and every other bit reads 0. `bus_addr`=0 selects bank A and `bus_addr`=1 selects bank B. `bus_rdata` shows the selected word in the same cycle.
- R3: In bank A, a `done_a[n]` pulse sets flag 24+n at the next edge only if enable 16+n is set at that time. Otherwise the pulse has no effect.
- R4: In bank B, pulses on channels 2 and 3 always set their flags, even with the enable clear. Channels 0, 1, 4 and 5 follow the R3 rule.
- R5: When a flag is latched, or a rescan hits, while bit 23 holds 1, bit 31 reads 1 after that edge. Bit 31 is read-only, so writes to it have no effect.
- R6: Bit 31 clears at the edge after which no flag remains set whose channel is enabled (or, in bank B, is channel 2 or 3).
- R7: A write of 1 to a flag bit clears that flag, and a write of 0 leaves it unchanged. Enable bits and bit 23 take the written value.
- R8: If a completion pulse and a clearing write hit the same flag in the same cycle, the flag remains set.
- R9: `irq` is registered. After an edge that accepted a pulse or a rescan hit, it is high for at least one cycle. It stays high for as long as either bit 31 is set, and is low otherwise.
- R10: A rescan asserts `irq` only if some flag qualifies under the R6 rule. It leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high (with bus_en) |
| bus_addr | input | 1 | Bank select (0 = A, 1 = B) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of selected bank |
| done_a | input | 6 | Completion pulses, bank A channels |
| done_b | input | 6 | Completion pulses, bank B channels |
| rescan_a | input | 1 | Rescan strobe, bank A |
| rescan_b | input | 1 | Rescan strobe, bank B |
| irq | output | 1 | Level interrupt request to controller input 3 |

## Verification
A DMA completion and a CPU write that clears the same flag can arrive in one cycle. The bench provokes this by driving the pulse and the write-one-to-clear on the same falling edge. It reads the word after the capturing edge and expects the flag still set (R8). A second overlap is a write that removes a channel's enable while its flag stays pending. In that case the master flag must drop in the same edge while the flag itself survives. The bench judges this from the read value and from `irq` (R6).

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int DW     = 32;
  localparam int NCH    = 6;
  localparam int NBANK  = 2;
  localparam int EN_LSB = 16;
  localparam int ME_BIT = 23;
  localparam int FL_LSB = 24;
  localparam int MF_BIT = 31;

  localparam logic [DW-1:0] EN_MASK  = DW'({NCH{1'b1}}) << EN_LSB;
  localparam logic [DW-1:0] FL_MASK  = DW'({NCH{1'b1}}) << FL_LSB;
  localparam logic [DW-1:0] ME_MASK  = DW'(1) << ME_BIT;
  localparam logic [DW-1:0] CFG_MASK = EN_MASK | ME_MASK;

  typedef logic [DW-1:0]  word_t;
  typedef logic [NCH-1:0] chan_t;
endpackage

// File: rtl/dic_bank.sv
module dic_bank
  import dic_pkg::*;
#(
  parameter chan_t FORCED = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  word_t wdata,
  input  chan_t done,
  input  logic  rescan,
  output word_t word,
  output logic  mflag_nxt,
  output logic  fire
);
  word_t q, d, cfg_d, clr, acc_w;
  chan_t en_q, flag_q, en_d, flag_d, accept, qual_now;
  logic  men_q, mf_q, rescan_hit, pend_d;

  assign en_q   = q[EN_LSB +: NCH];
  assign flag_q = q[FL_LSB +: NCH];
  assign men_q  = q[ME_BIT];
  assign mf_q   = q[MF_BIT];

  always_comb begin
    accept     = done & (en_q | FORCED);
    qual_now   = flag_q & (en_q | FORCED);
    rescan_hit = rescan && (qual_now != '0);
    fire       = (accept != '0) || rescan_hit;

    cfg_d = wr ? (wdata & CFG_MASK) : (q & CFG_MASK);
    clr   = wr ? (wdata & FL_MASK) : '0;
    acc_w = DW'(accept) << FL_LSB;

    d      = cfg_d | ((q & FL_MASK & ~clr) | acc_w);
    en_d   = d[EN_LSB +: NCH];
    flag_d = d[FL_LSB +: NCH];
    pend_d = (flag_d & (en_d | FORCED)) != '0;
    mflag_nxt = pend_d && (mf_q || (fire && men_q));
    d[MF_BIT] = mflag_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign word = q;
endmodule

// File: rtl/dic_bus.sv
module dic_bus
  import dic_pkg::*;
(
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic                  bus_addr,
  input  word_t [NBANK-1:0]     words,
  output logic  [NBANK-1:0]     wr_sel,
  output word_t                 rdata
);
  always_comb begin
    for (int b = 0; b < NBANK; b++)
      wr_sel[b] = bus_en && bus_we && (int'(bus_addr) == b);
    rdata = words[bus_addr];
  end
endmodule

// File: rtl/dic_irq_out.sv
module dic_irq_out
  import dic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] mflag_nxt,
  input  logic [NBANK-1:0] fire,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (mflag_nxt != '0) || (fire != '0);
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dic_pkg::*;
#(
  parameter logic [5:0] FORCED_B = 6'b001100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [5:0]  done_a,
  input  logic [5:0]  done_b,
  input  logic        rescan_a,
  input  logic        rescan_b,
  output logic        irq
);
  word_t [NBANK-1:0] bank_word;
  chan_t [NBANK-1:0] done_v;
  logic  [NBANK-1:0] rescan_v, wr_sel, mflag_nxt, fire;

  assign done_v   = {done_b, done_a};
  assign rescan_v = {rescan_b, rescan_a};

  dic_bus u_bus (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .words(bank_word), .wr_sel(wr_sel), .rdata(bus_rdata)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam chan_t FMASK = (b == 1) ? chan_t'(FORCED_B) : '0;
    dic_bank #(.FORCED(FMASK)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(wr_sel[b]), .wdata(bus_wdata),
      .done(done_v[b]), .rescan(rescan_v[b]), .word(bank_word[b]),
      .mflag_nxt(mflag_nxt[b]), .fire(fire[b])
    );
  end

  dic_irq_out u_irq (
    .clk(clk), .rst_n(rst_n), .mflag_nxt(mflag_nxt), .fire(fire), .irq(irq)
  );
endmodule

// File: rtl/dic_chk.sv
module dic_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic        bus_we,
  input logic        bus_addr,
  input logic [5:0]  done_a,
  input logic [5:0]  done_b,
  input logic        rescan_b,
  input logic        irq,
  input logic [31:0] reg_a,
  input logic [31:0] reg_b
);
  // R3
  a_enabled_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_a & reg_a[21:16]) != 6'd0) |=>
      ((reg_a[29:24] & $past(done_a & reg_a[21:16])) == $past(done_a & reg_a[21:16])));
  // R3
  a_masked_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reg_a[29:24] & ~$past(reg_a[29:24]) & ~$past(reg_a[21:16])) == 6'd0));
  // R4
  b_forced_ch2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_b[2] |=> reg_b[26]);
  // R4
  b_forced_ch3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_b[3] |=> reg_b[27]);
  // R6
  a_master_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_a[31] |-> ((reg_a[29:24] & reg_a[21:16]) != 6'd0));
  // R9
  irq_follows_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_a[31] || reg_b[31]) |-> irq);
  // R10
  b_rescan_flags_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rescan_b && !(bus_en && bus_we && bus_addr) && done_b == 6'd0) |=>
      (reg_b[29:24] == $past(reg_b[29:24])));
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_a[30] == 1'b0) && (reg_a[22] == 1'b0) && (reg_a[15:0] == 16'd0) &&
    (reg_b[30] == 1'b0) && (reg_b[22] == 1'b0) && (reg_b[15:0] == 16'd0));
endmodule

bind dma_irq_ctrl dic_chk u_dic_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .done_a(done_a), .done_b(done_b), .rescan_b(rescan_b), .irq(irq),
  .reg_a(bank_word[0]), .reg_b(bank_word[1])
);

// File: tb/test_dma_irq_ctrl.sv
module test_dma_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  done_a = '0, done_b = '0;
  logic        rescan_a = 1'b0, rescan_b = 1'b0;
  logic        irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dma_irq_ctrl i_dma_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_a(done_a), .done_b(done_b),
    .rescan_a(rescan_a), .rescan_b(rescan_b), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(string tag, logic b, logic [31:0] exp);
    bus_addr = b;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(logic b, logic [31:0] data);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = b; bus_wdata = data;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic pulse(logic b, logic [5:0] m);
    if (b) done_b = m; else done_a = m;
    @(negedge clk);
    done_a = '0; done_b = '0;
  endtask

  task automatic rescan(logic b);
    if (b) rescan_b = 1'b1; else rescan_a = 1'b1;
    @(negedge clk);
    rescan_a = 1'b0; rescan_b = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 bank A", 1'b0, 32'h0);
    rd_chk("R1 bank B", 1'b1, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_layout;
    wr(1'b0, 32'hFFFF_FFFF);
    rd_chk("R2 R5 R7 all-ones write", 1'b0, 32'h00BF_0000);
    chk("R2 irq quiet", {31'd0, irq}, 32'd0);
    wr(1'b0, 32'h0000_0000);
  endtask

  task automatic t_mask_a;
    wr(1'b0, 32'h0005_0000);
    pulse(1'b0, 6'b000011);
    rd_chk("R3 only enabled ch0 latches", 1'b0, 32'h0105_0000);
    chk("R9 irq pulse on accept", {31'd0, irq}, 32'd1);
    @(negedge clk);
    chk("R9 irq drops w/o master", {31'd0, irq}, 32'd0);
    wr(1'b0, 32'h3F00_0000);
  endtask

  task automatic t_forced_b;
    wr(1'b1, 32'h3F00_0000);
    pulse(1'b1, 6'b111111);
    rd_chk("R4 ch2/ch3 forced", 1'b1, 32'h0C00_0000);
    chk("R4 irq fires", {31'd0, irq}, 32'd1);
    wr(1'b1, 32'h3F00_0000);
  endtask

  task automatic t_master;
    wr(1'b0, 32'h3F81_0000);
    pulse(1'b0, 6'b000001);
    rd_chk("R5 master set", 1'b0, 32'h8181_0000);
    @(negedge clk);
    chk("R9 irq held", {31'd0, irq}, 32'd1);
    wr(1'b0, 32'h0181_0000);
    rd_chk("R7 w1c clears flag and master", 1'b0, 32'h0081_0000);
    chk("R9 irq low after clear", {31'd0, irq}, 32'd0);
    pulse(1'b0, 6'b000001);
    wr(1'b0, 32'h0080_0000);
    rd_chk("R6 disable drops master", 1'b0, 32'h0180_0000);
    chk("R6 irq low", {31'd0, irq}, 32'd0);
    wr(1'b0, 32'h3F00_0000);
  endtask

  task automatic t_collision;
    wr(1'b0, 32'h0002_0000);
    pulse(1'b0, 6'b000010);
    done_a = 6'b000010;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 32'h0202_0000;
    @(negedge clk);
    done_a = '0; bus_en = 1'b0; bus_we = 1'b0;
    rd_chk("R8 completion beats clear", 1'b0, 32'h0202_0000);
    wr(1'b0, 32'h0202_0000);
    rd_chk("R7 plain clear", 1'b0, 32'h0002_0000);
    wr(1'b0, 32'h3F00_0000);
  endtask

  task automatic t_rescan;
    wr(1'b0, 32'h0010_0000);
    pulse(1'b0, 6'b010000);
    @(negedge clk);
    wr(1'b0, 32'h0090_0000);
    rd_chk("R5 write of me does not set master", 1'b0, 32'h1090_0000);
    chk("R10 irq idle before rescan", {31'd0, irq}, 32'd0);
    rescan(1'b0);
    rd_chk("R10 rescan A sets master", 1'b0, 32'h9090_0000);
    chk("R10 irq after rescan", {31'd0, irq}, 32'd1);
    wr(1'b0, 32'h3F00_0000);
    wr(1'b1, 32'h3F00_0000);
    pulse(1'b1, 6'b000100);
    @(negedge clk);
    wr(1'b1, 32'h0080_0000);
    rescan(1'b1);
    rd_chk("R10 rescan B forced ch2", 1'b1, 32'h8480_0000);
    chk("R9 irq from bank B master", {31'd0, irq}, 32'd1);
    wr(1'b1, 32'h3F00_0000);
    @(negedge clk);
    rescan(1'b1);
    chk("R10 empty rescan no irq", {31'd0, irq}, 32'd0);
    rd_chk("R10 empty rescan no flags", 1'b1, 32'h0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_mask_a();
    t_forced_b();
    t_master();
    t_collision();
    t_rescan();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule